// File: doc/BRIEF.md
# Scan-Line Framer with Fill, Skip Flag and Alignment Padding

This block frames the serial output of a one-dimensional run-length coder into a facsimile-style bit stream. A line is opened by a command strobe together with a flag that says whether the line is entirely white. The framer then emits a 12-bit end-of-line marker. When skip mode is on, a one-bit skip flag follows. After that come the line's code bits, taken through a valid/ready stream that ends with a last-bit marker. Zero fill follows until the line reaches a programmed minimum length. When padding is on, zeros then bring the line to a byte boundary. In skip mode an all-white line is shortened: its code bits are consumed and discarded, and the line is filled only to half the minimum length.

A separate page-end command emits a programmable number of back-to-back end-of-line markers, which close the page. The line length is counted from the first bit of the end-of-line marker. The output is a single bit with a valid/ready handshake. The code input is stalled whenever the framer is inserting bits of its own.

Top module: `fax_line_framer`

## Requirements
- R1: Every line begins with the 12-bit marker 000000000001 (eleven zeros, then a one, first bit first on `out_bit`).
- R2: With `cfg_skip_en`=1, exactly one flag bit follows the marker: 1 if the line was flagged white, 0 otherwise. With `cfg_skip_en`=0, no flag bit is sent.
- R3: For a line that is not skipped, every code bit up to and including the one marked `code_last` appears on the output unchanged and in order, right after the marker (and flag).
- R4: After the code bits, zero bits are added until the line, counted from the first marker bit, holds at least `cfg_min_bits` bits. A line already at or above that length gets no fill.
- R5: With `cfg_skip_en`=1 and the white flag set, the line's code bits are consumed and dropped. Before padding, the line is max(13, floor(`cfg_min_bits`/2)) bits long and contains only the marker, the flag bit 1 and zeros.
- R6: With `cfg_pad_en`=1, zeros are appended after the fill until the line length is a multiple of 8. A line that is already a multiple of 8 gets none. With `cfg_pad_en`=0, no padding is added.
- R7: A page-end command emits `cfg_rtc_eols` consecutive 12-bit markers and nothing else. A count of 0 emits no bits.
- R8: Commands are taken only while `cmd_ready` is 1, and the configuration is sampled at that moment. If `line_start` and `page_end` arrive in the same cycle, the line is started and the page-end is dropped.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_bit` hold. `code_ready` is 1 only while a code bit passes straight to an accepting output, or while code bits are being dropped.
- R10: After reset, `cmd_ready`=1, `out_valid`=0 and `code_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_min_bits | input | MIN_W | Minimum bits per line |
| cfg_skip_en | input | 1 | Skip mode enable |
| cfg_pad_en | input | 1 | Byte-alignment padding enable |
| cfg_rtc_eols | input | RTC_W | Number of markers in the page-end sequence |
| line_start | input | 1 | Open a new line |
| line_white | input | 1 | The line being opened is entirely white |
| page_end | input | 1 | Emit the page-end sequence |
| cmd_ready | output | 1 | Framer idle; commands are accepted |
| code_valid | input | 1 | Code bit available |
| code_bit | input | 1 | Code bit value |
| code_last | input | 1 | Final code bit of the line |
| code_ready | output | 1 | Code bit consumed this cycle |
| out_valid | output | 1 | Output bit available |
| out_bit | output | 1 | Output bit value |
| out_ready | input | 1 | Downstream accepts the output bit |

## Verification
The hardest case to reach is a line where several conditions meet at once. The minimum length, the halving for a skipped white line, and byte alignment interact; on top of that, a back-pressured output stalls a passthrough bit. Small minimums make the 13-bit floor the binding limit for a skipped line. Code lengths that land exactly on a multiple of 8 must get no pad. The stimulus reaches these cases with directed lines built for those exact lengths. Random lines then vary the minimum, the code length, both modes and the output-ready duty cycle, and each line's bits are compared with a stream assembled by a bench model.

// File: rtl/fax_frm_pkg.sv
package fax_frm_pkg;

   localparam int unsigned EOL_LEN = 12;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_EOL,
      ST_SKIP,
      ST_DATA,
      ST_DROP,
      ST_FILL,
      ST_PAD,
      ST_RTC
   } frm_state_e;

endpackage

// File: rtl/fax_eol_ser.sv
module fax_eol_ser #(
   parameter int unsigned LEN = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic advance,
   output logic bit_o,
   output logic last_o
);
   localparam int unsigned IDX_W = (LEN > 1) ? $clog2(LEN) : 1;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LEN - 1);

   logic [IDX_W-1:0] idx_q;

   assign last_o = (idx_q == IDX_LAST);
   assign bit_o  = last_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (clr) begin
         idx_q <= '0;
      end else if (advance) begin
         idx_q <= last_o ? '0 : idx_q + 1'b1;
      end
   end
endmodule

// File: rtl/fax_line_cnt.sv
module fax_line_cnt #(
   parameter int unsigned CNT_W      = 20,
   parameter int unsigned MIN_W      = 16,
   parameter int unsigned ALIGN_BITS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [MIN_W-1:0] target,
   output logic             reached,
   output logic             aligned
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;

   assign reached = (cnt_q >= {{(CNT_W-MIN_W){1'b0}}, target});

   generate
      if (ALIGN_BITS <= 1) begin : g_no_align
         assign aligned = 1'b1;
      end else begin : g_align
         localparam int unsigned AL_W = $clog2(ALIGN_BITS);
         assign aligned = (cnt_q[AL_W-1:0] == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (inc && (cnt_q != CNT_MAX)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/fax_rtc_ctr.sv
module fax_rtc_ctr #(
   parameter int unsigned RTC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [RTC_W-1:0] load_val,
   input  logic             dec,
   output logic             zero
);
   logic [RTC_W-1:0] left_q;

   assign zero = (left_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (load) begin
         left_q <= load_val;
      end else if (dec && !zero) begin
         left_q <= left_q - 1'b1;
      end
   end
endmodule

// File: rtl/fax_line_framer.sv
module fax_line_framer
   import fax_frm_pkg::*;
#(
   parameter int unsigned CNT_W      = 20,
   parameter int unsigned MIN_W      = 16,
   parameter int unsigned RTC_W      = 8,
   parameter int unsigned ALIGN_BITS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [MIN_W-1:0] cfg_min_bits,
   input  logic             cfg_skip_en,
   input  logic             cfg_pad_en,
   input  logic [RTC_W-1:0] cfg_rtc_eols,
   input  logic             line_start,
   input  logic             line_white,
   input  logic             page_end,
   output logic             cmd_ready,
   input  logic             code_valid,
   input  logic             code_bit,
   input  logic             code_last,
   output logic             code_ready,
   output logic             out_valid,
   output logic             out_bit,
   input  logic             out_ready
);
   generate
      if (CNT_W <= MIN_W) begin : g_bad_cnt
         $error("fax_line_framer: CNT_W must exceed MIN_W");
      end
      if ((ALIGN_BITS & (ALIGN_BITS - 1)) != 0) begin : g_bad_align
         $error("fax_line_framer: ALIGN_BITS must be a power of two");
      end
      if (RTC_W < 1) begin : g_bad_rtc
         $error("fax_line_framer: RTC_W must be at least 1");
      end
   endgenerate

   frm_state_e       state_q, state_d;
   logic             white_q, skip_q, pad_q;
   logic [MIN_W-1:0] target_q;

   logic accept_line, accept_page, out_fire;
   logic eol_bit, eol_last, eol_adv;
   logic reached, aligned, rtc_zero, rtc_dec;

   assign cmd_ready   = (state_q == ST_IDLE);
   assign accept_line = cmd_ready && line_start;
   assign accept_page = cmd_ready && page_end && !line_start;
   assign out_fire    = out_valid && out_ready;
   assign eol_adv     = out_fire && ((state_q == ST_EOL) || (state_q == ST_RTC));
   assign rtc_dec     = out_fire && (state_q == ST_RTC) && eol_last;

   fax_eol_ser #(.LEN(EOL_LEN)) eol_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (accept_line || accept_page),
      .advance (eol_adv),
      .bit_o   (eol_bit),
      .last_o  (eol_last)
   );

   fax_line_cnt #(
      .CNT_W      (CNT_W),
      .MIN_W      (MIN_W),
      .ALIGN_BITS (ALIGN_BITS)
   ) cnt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (accept_line),
      .inc     (out_fire),
      .target  (target_q),
      .reached (reached),
      .aligned (aligned)
   );

   fax_rtc_ctr #(.RTC_W(RTC_W)) rtc_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept_page),
      .load_val (cfg_rtc_eols),
      .dec      (rtc_dec),
      .zero     (rtc_zero)
   );

   always_comb begin
      state_d    = state_q;
      out_valid  = 1'b0;
      out_bit    = 1'b0;
      code_ready = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (accept_line)      state_d = ST_EOL;
            else if (accept_page) state_d = ST_RTC;
         end
         ST_EOL: begin
            out_valid = 1'b1;
            out_bit   = eol_bit;
            if (out_ready && eol_last) state_d = skip_q ? ST_SKIP : ST_DATA;
         end
         ST_SKIP: begin
            out_valid = 1'b1;
            out_bit   = white_q;
            if (out_ready) state_d = white_q ? ST_DROP : ST_DATA;
         end
         ST_DATA: begin
            out_valid  = code_valid;
            out_bit    = code_bit;
            code_ready = out_ready;
            if (code_valid && out_ready && code_last) state_d = ST_FILL;
         end
         ST_DROP: begin
            code_ready = 1'b1;
            if (code_valid && code_last) state_d = ST_FILL;
         end
         ST_FILL: begin
            if (!reached) out_valid = 1'b1;
            else          state_d   = ST_PAD;
         end
         ST_PAD: begin
            if (pad_q && !aligned) out_valid = 1'b1;
            else                   state_d   = ST_IDLE;
         end
         ST_RTC: begin
            if (rtc_zero) begin
               state_d = ST_IDLE;
            end else begin
               out_valid = 1'b1;
               out_bit   = eol_bit;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         white_q  <= 1'b0;
         skip_q   <= 1'b0;
         pad_q    <= 1'b0;
         target_q <= '0;
      end else begin
         state_q <= state_d;
         if (accept_line) begin
            skip_q   <= cfg_skip_en;
            pad_q    <= cfg_pad_en;
            white_q  <= cfg_skip_en && line_white;
            target_q <= (cfg_skip_en && line_white) ? (cfg_min_bits >> 1) : cfg_min_bits;
         end
      end
   end
endmodule

// File: rtl/fax_line_framer_chk.sv
module fax_line_framer_chk (
   input logic clk,
   input logic rst_n,
   input logic line_start,
   input logic page_end,
   input logic cmd_ready,
   input logic code_ready,
   input logic out_valid,
   input logic out_bit,
   input logic out_ready
);
   // R9: a stalled output bit does not change or vanish
   assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

   // R9: a consumed code bit is either forwarded or dropped, never lost to a stall
   assert_pass_no_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (code_ready && out_valid) |-> out_ready);

   // R8: an idle framer emits nothing and consumes nothing
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (!out_valid && !code_ready));

   // R8: a command taken while ready makes the framer busy
   assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ready && (line_start || page_end)) |=> !cmd_ready);
endmodule

bind fax_line_framer fax_line_framer_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .line_start (line_start),
   .page_end   (page_end),
   .cmd_ready  (cmd_ready),
   .code_ready (code_ready),
   .out_valid  (out_valid),
   .out_bit    (out_bit),
   .out_ready  (out_ready)
);

// File: tb/fax_line_framer_tb_top.sv
module fax_line_framer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cfg_min_bits = '0;
   logic        cfg_skip_en = 1'b0;
   logic        cfg_pad_en = 1'b0;
   logic [7:0]  cfg_rtc_eols = '0;
   logic        line_start = 1'b0;
   logic        line_white = 1'b0;
   logic        page_end = 1'b0;
   logic        cmd_ready;
   logic        code_valid = 1'b0;
   logic        code_bit = 1'b0;
   logic        code_last = 1'b0;
   logic        code_ready;
   logic        out_valid;
   logic        out_bit;
   logic        out_ready = 1'b1;

   int n_checks = 0;
   int n_errors = 0;
   int ready_mode = 0;   // 0: always ready, 1: random stalls
   bit got_q[$];
   bit exp_q[$];
   bit code_q[$];

   always #5 clk = ~clk;

   fax_line_framer dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_min_bits (cfg_min_bits),
      .cfg_skip_en  (cfg_skip_en),
      .cfg_pad_en   (cfg_pad_en),
      .cfg_rtc_eols (cfg_rtc_eols),
      .line_start   (line_start),
      .line_white   (line_white),
      .page_end     (page_end),
      .cmd_ready    (cmd_ready),
      .code_valid   (code_valid),
      .code_bit     (code_bit),
      .code_last    (code_last),
      .code_ready   (code_ready),
      .out_valid    (out_valid),
      .out_bit      (out_bit),
      .out_ready    (out_ready)
   );

   // output monitor: samples mid-cycle, before the edge that completes the handshake
   initial forever begin
      @(negedge clk);
      #2;
      if (rst_n && out_valid && out_ready) got_q.push_back(out_bit);
   end

   // output back-pressure
   initial forever begin
      @(negedge clk);
      out_ready = (ready_mode == 0) ? 1'b1 : (($urandom % 4) != 0);
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic void push_eol();
      for (int i = 0; i < 11; i++) exp_q.push_back(1'b0);
      exp_q.push_back(1'b1);
   endfunction

   // bench model of one framed line
   function automatic void model_line(input int min_bits, input bit skip,
                                      input bit pad, input bit white);
      int target;
      exp_q.delete();
      push_eol();
      if (skip) exp_q.push_back(white);
      if (!(skip && white)) foreach (code_q[i]) exp_q.push_back(code_q[i]);
      target = (skip && white) ? (min_bits / 2) : min_bits;
      while (exp_q.size() < target) exp_q.push_back(1'b0);
      if (pad) while ((exp_q.size() % 8) != 0) exp_q.push_back(1'b0);
   endfunction

   task automatic compare_stream(input string tag);
      int bad = -1;
      check(got_q.size() == exp_q.size(), tag, "stream length", got_q.size(), exp_q.size());
      if (got_q.size() == exp_q.size()) begin
         foreach (exp_q[i]) if (bad < 0 && got_q[i] != exp_q[i]) bad = i;
         check(bad < 0, tag, "first mismatching bit index", bad, -1);
      end
      got_q.delete();
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
   endtask

   task automatic send_code();
      foreach (code_q[i]) begin
         if (($urandom % 3) == 0) @(negedge clk);
         code_valid = 1'b1;
         code_bit   = code_q[i];
         code_last  = (i == code_q.size() - 1);
         #2;
         while (!code_ready) begin
            @(negedge clk);
            #2;
         end
         @(negedge clk);
         code_valid = 1'b0;
         code_last  = 1'b0;
         code_bit   = 1'b0;
      end
   endtask

   task automatic run_line(input int min_bits, input bit skip, input bit pad,
                           input bit white, input int ncode, input string tag);
      code_q.delete();
      for (int i = 0; i < ncode; i++) code_q.push_back(1'($urandom % 2));
      wait_idle();
      cfg_min_bits = 16'(min_bits);
      cfg_skip_en  = skip;
      cfg_pad_en   = pad;
      line_white   = white;
      line_start   = 1'b1;
      @(negedge clk);
      line_start   = 1'b0;
      send_code();
      wait_idle();
      model_line(min_bits, skip, pad, white);
      compare_stream(tag);
   endtask

   task automatic run_page(input int n, input string tag);
      wait_idle();
      cfg_rtc_eols = 8'(n);
      page_end     = 1'b1;
      @(negedge clk);
      page_end     = 1'b0;
      wait_idle();
      exp_q.delete();
      for (int i = 0; i < n; i++) push_eol();
      compare_stream(tag);
   endtask

   initial begin
      void'($urandom(32'h5eed_0f4a));
      repeat (3) @(negedge clk);
      // R10: reset state
      check(cmd_ready == 1'b1, "R10", "cmd_ready in reset", cmd_ready, 1);
      check(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
      check(code_ready == 1'b0, "R10", "code_ready in reset", code_ready, 0);
      rst_n = 1'b1;

      // directed corner cases
      run_line(0,   0, 0, 0, 5,  "R1 R3 no-fill");
      run_line(100, 0, 0, 0, 9,  "R4 fill to minimum");
      run_line(20,  0, 0, 1, 30, "R4 long line no fill, white ignored without skip");
      run_line(100, 1, 0, 1, 25, "R2 R5 skipped white line");
      run_line(40,  1, 0, 0, 10, "R2 R3 R4 skip flag zero");
      run_line(10,  1, 0, 1, 6,  "R5 floor of 13 bits");
      run_line(10,  1, 1, 1, 6,  "R5 R6 floor then pad");
      run_line(0,   0, 1, 0, 7,  "R6 pad 19 to 24");
      run_line(0,   0, 1, 0, 4,  "R6 already aligned");
      run_line(33,  0, 1, 0, 4,  "R4 R6 fill then pad");
      run_page(3, "R7 three markers");
      run_page(0, "R7 zero markers");

      // R8: simultaneous commands, line wins, page-end dropped
      code_q.delete();
      for (int i = 0; i < 8; i++) code_q.push_back(1'($urandom % 2));
      wait_idle();
      cfg_min_bits = 16'd0; cfg_skip_en = 1'b0; cfg_pad_en = 1'b0;
      cfg_rtc_eols = 8'd2; line_white = 1'b0;
      line_start = 1'b1; page_end = 1'b1;
      @(negedge clk);
      line_start = 1'b0; page_end = 1'b0;
      send_code();
      wait_idle();
      model_line(0, 0, 0, 0);
      compare_stream("R8 line over page-end");
      repeat (30) @(negedge clk);
      check(got_q.size() == 0, "R8", "bits after dropped page-end", got_q.size(), 0);
      check(cmd_ready == 1'b1, "R8", "idle after dropped page-end", cmd_ready, 1);

      // R8: configuration sampled at acceptance, changed while busy
      code_q.delete();
      for (int i = 0; i < 5; i++) code_q.push_back(1'($urandom % 2));
      wait_idle();
      cfg_min_bits = 16'd50; cfg_skip_en = 1'b0; cfg_pad_en = 1'b0; line_white = 1'b0;
      line_start = 1'b1;
      @(negedge clk);
      line_start = 1'b0;
      cfg_min_bits = 16'd0; cfg_pad_en = 1'b1; cfg_skip_en = 1'b1;
      send_code();
      wait_idle();
      model_line(50, 0, 0, 0);
      compare_stream("R8 config held from acceptance");

      // random lines under back-pressure
      ready_mode = 1;
      for (int n = 0; n < 60; n++) begin
         run_line(int'($urandom % 300), 1'($urandom % 2), 1'($urandom % 2),
                  1'($urandom % 2), 1 + int'($urandom % 60), "R9 random line");
         if ((n % 20) == 19) run_page(int'($urandom % 5), "R7 R9 random page-end");
      end

      ready_mode = 0;
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule